// File: doc/BRIEF.md
# Two-Way Write-Back Data Cache Controller

This block is a data cache with two ways per set. A processor presents one request at a time on a ready/valid port: a read, or a write with per-byte enables. The controller compares the request tag against both ways of the indexed set at once. A hit is served from the local array. A miss fetches the whole block from the next memory level. Writes never go to memory directly. They update the array and mark the line dirty. A write miss first allocates and refills the block, the same way a read miss does, and then merges the enabled bytes.

When a set is full, the line to replace is named by a single per-set pointer that flips on every refill. This gives first-in, first-out order. Before the pointer is used, an empty way is filled if one exists. A displaced line that carries modified data is sent whole to an external victim/write-back buffer. A clean displaced line is simply dropped. If the buffer signals that it is full while a dirty line must leave, the request waits until space appears. Hits and clean misses are not affected by that condition.

Top module: `cache_2way_wb`

## Requirements
- R1: A request address splits into a tag (bits ADDR_W-1 down to OFF_W+IDX_W), a set index (bits OFF_W+IDX_W-1 down to OFF_W) and a word select (bits OFF_W-1 down to 2 for 32-bit data). The two lowest bits do not change which word is accessed.
- R2: Both ways of the indexed set are compared in the same cycle, and at most one way hits. A hit performs no memory refill, and a read hit returns the stored word.
- R3: After the clock edge that accepts a read or write hit (req_valid and req_ready both high), rsp_valid goes high after exactly the third following rising edge and stays high for one cycle. req_ready is low from acceptance through the response cycle.
- R4: A write changes only the bytes whose enable bit is set. Bit i of req_be guards req_wdata[8i+7:8i]. The write takes effect only after the tag check has found or installed the line.
- R5: A write miss allocates the block and refills it from memory, then merges the write. A later read returns the merged word.
- R6: On a miss, the first invalid way is filled, way 0 before way 1. If both ways are valid, the way named by the set's pointer is replaced. Every pointer resets to way 0 and flips on every refill of its set.
- R7: A dirty victim is sent out with evict_valid high for one cycle. evict_addr is the block-aligned address of the old line, and word w of the block sits at evict_data[32w+31:32w]. The eviction comes before the refill request.
- R8: A clean victim is discarded, and evict_valid stays low for that miss.
- R9: While evict_full is high and a dirty victim is waiting, there is no eviction, no refill request and no response. The miss proceeds once evict_full falls.
- R10: evict_full has no effect on hits or on misses whose victim is clean. A read hit keeps the latency of R3 while it is high.
- R11: After reset every line is invalid, req_ready is high, and rsp_valid, mem_req_valid and evict_valid are low.
- R12: On a refill, mem_req_valid is held with the block-aligned mem_req_addr until a one-cycle mem_rsp_valid. Word w of the block arrives on mem_rsp_data[32w+31:32w].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Processor request present, held until the response |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_be | input | DATA_W/8 | Byte enables for a write |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read data, valid with rsp_valid on a read |
| mem_req_valid | output | 1 | Block refill request |
| mem_req_addr | output | ADDR_W | Block-aligned refill address |
| mem_rsp_valid | input | 1 | Refill data present |
| mem_rsp_data | input | BLOCK_BYTES*8 | Whole refill block |
| evict_full | input | 1 | Victim buffer cannot take a block |
| evict_valid | output | 1 | Dirty block handed to the victim buffer |
| evict_addr | output | ADDR_W | Block-aligned address of the evicted line |
| evict_data | output | BLOCK_BYTES*8 | Evicted block contents |

## Verification
Two functions can overlap. The first overlap is a full victim buffer during a read hit. The bench raises evict_full and reads a resident line. The hit must still answer on the third edge, with the right data. The second overlap is the same buffer condition during a miss whose victim is dirty. The bench holds evict_full for twenty cycles and observes that no eviction, refill or response happens in that time. It then releases the buffer and checks the evicted address and the merged word, and that the new line still returns correct data. The replacement order is judged across a sequence on one set, by which old block leaves and which one stays resident.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;

   localparam int unsigned NUM_WAYS = 2;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_TAG,
      ST_EVICT,
      ST_FILL,
      ST_ACC,
      ST_RSP
   } ctl_state_e;

endpackage

// File: rtl/cache2w_tag_store.sv
module cache2w_tag_store
   import cache2w_pkg::*;
#(
   parameter int unsigned SETS  = 4,
   parameter int unsigned TAG_W = 8,
   parameter int unsigned IDX_W = $clog2(SETS)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [IDX_W-1:0]          lk_idx,
   input  logic [TAG_W-1:0]          lk_tag,
   output logic [NUM_WAYS-1:0]       hit_vec,
   output logic [NUM_WAYS-1:0]       valid_vec,
   output logic [NUM_WAYS-1:0]       dirty_vec,
   output logic [NUM_WAYS*TAG_W-1:0] tag_vec,
   output logic                      fifo_ptr,
   input  logic                      fill_en,
   input  logic                      fill_way,
   input  logic [TAG_W-1:0]          fill_tag,
   input  logic                      mark_dirty,
   input  logic                      dirty_way
);

   logic [SETS-1:0] fifo_q;

   // one pointer bit per set, flipped on every refill of that set
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fifo_q <= '0;
      end else if (fill_en) begin
         fifo_q[lk_idx] <= ~fifo_q[lk_idx];
      end
   end

   assign fifo_ptr = fifo_q[lk_idx];

   for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
      localparam logic WAY_ID = 1'(w);

      logic [TAG_W-1:0] tag_q [SETS];
      logic [SETS-1:0]  val_q;
      logic [SETS-1:0]  dty_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            val_q <= '0;
            dty_q <= '0;
         end else if (fill_en && fill_way == WAY_ID) begin
            val_q[lk_idx] <= 1'b1;
            dty_q[lk_idx] <= 1'b0;
         end else if (mark_dirty && dirty_way == WAY_ID) begin
            dty_q[lk_idx] <= 1'b1;
         end
      end

      always_ff @(posedge clk) begin
         if (fill_en && fill_way == WAY_ID) begin
            tag_q[lk_idx] <= fill_tag;
         end
      end

      assign valid_vec[w]               = val_q[lk_idx];
      assign dirty_vec[w]               = dty_q[lk_idx];
      assign tag_vec[w*TAG_W +: TAG_W]  = tag_q[lk_idx];
      assign hit_vec[w]                 = val_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
   end

endmodule

// File: rtl/cache2w_data_store.sv
module cache2w_data_store
   import cache2w_pkg::*;
#(
   parameter int unsigned SETS    = 4,
   parameter int unsigned IDX_W   = $clog2(SETS),
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned WORDS   = 16,
   parameter int unsigned WSEL_W  = $clog2(WORDS),
   parameter int unsigned BLOCK_W = DATA_W * WORDS
) (
   input  logic                 clk,
   input  logic [IDX_W-1:0]     idx,
   input  logic                 way,
   input  logic [WSEL_W-1:0]    wsel,
   input  logic                 wr_en,
   input  logic [DATA_W/8-1:0]  be,
   input  logic [DATA_W-1:0]    wdata,
   input  logic                 fill_en,
   input  logic [BLOCK_W-1:0]   fill_data,
   output logic [DATA_W-1:0]    rd_word,
   output logic [BLOCK_W-1:0]   rd_block
);

   localparam int unsigned BYTES = DATA_W / 8;

   logic [BLOCK_W-1:0] way_blk [NUM_WAYS];

   for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
      localparam logic WAY_ID = 1'(w);

      logic [BLOCK_W-1:0] blk_q [SETS];

      always_ff @(posedge clk) begin
         if (fill_en && way == WAY_ID) begin
            blk_q[idx] <= fill_data;
         end else if (wr_en && way == WAY_ID) begin
            for (int b = 0; b < BYTES; b++) begin
               if (be[b]) begin
                  blk_q[idx][int'(wsel)*DATA_W + b*8 +: 8] <= wdata[b*8 +: 8];
               end
            end
         end
      end

      assign way_blk[w] = blk_q[idx];
   end

   assign rd_block = way_blk[way];
   assign rd_word  = rd_block[int'(wsel)*DATA_W +: DATA_W];

endmodule

// File: rtl/cache_2way_wb.sv
module cache_2way_wb
   import cache2w_pkg::*;
#(
   parameter int unsigned ADDR_W         = 16,
   parameter int unsigned DATA_W         = 32,
   parameter int unsigned BLOCK_BYTES    = 64,
   parameter int unsigned CAPACITY_BYTES = 512
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   output logic                     req_ready,
   input  logic                     req_write,
   input  logic [ADDR_W-1:0]        req_addr,
   input  logic [DATA_W/8-1:0]      req_be,
   input  logic [DATA_W-1:0]        req_wdata,
   output logic                     rsp_valid,
   output logic [DATA_W-1:0]        rsp_rdata,
   output logic                     mem_req_valid,
   output logic [ADDR_W-1:0]        mem_req_addr,
   input  logic                     mem_rsp_valid,
   input  logic [BLOCK_BYTES*8-1:0] mem_rsp_data,
   input  logic                     evict_full,
   output logic                     evict_valid,
   output logic [ADDR_W-1:0]        evict_addr,
   output logic [BLOCK_BYTES*8-1:0] evict_data
);

   localparam int unsigned SETS    = CAPACITY_BYTES / (NUM_WAYS * BLOCK_BYTES);
   localparam int unsigned OFF_W   = $clog2(BLOCK_BYTES);
   localparam int unsigned IDX_W   = $clog2(SETS);
   localparam int unsigned TAG_W   = ADDR_W - OFF_W - IDX_W;
   localparam int unsigned BYTES_W = DATA_W / 8;
   localparam int unsigned BSEL_W  = $clog2(BYTES_W);
   localparam int unsigned WORDS   = BLOCK_BYTES / BYTES_W;
   localparam int unsigned WSEL_W  = $clog2(WORDS);
   localparam int unsigned BLOCK_W = BLOCK_BYTES * 8;

   // elaboration-time parameter checks
   if ((1 << OFF_W) != BLOCK_BYTES) begin : g_bad_block
      $error("BLOCK_BYTES must be a power of two");
   end
   if (SETS < 2 || (1 << IDX_W) != SETS) begin : g_bad_sets
      $error("CAPACITY_BYTES must give a power-of-two set count of at least 2");
   end
   if (DATA_W < 8 || (1 << $clog2(DATA_W)) != DATA_W) begin : g_bad_data
      $error("DATA_W must be a power of two of at least 8");
   end
   if (WORDS < 2) begin : g_bad_words
      $error("a block must hold at least two data words");
   end
   if (ADDR_W <= OFF_W + IDX_W) begin : g_bad_addr
      $error("ADDR_W leaves no tag bits");
   end

   ctl_state_e          st;
   logic                q_write;
   logic [TAG_W-1:0]    q_tag;
   logic [IDX_W-1:0]    q_idx;
   logic [WSEL_W-1:0]   q_wsel;
   logic [BYTES_W-1:0]  q_be;
   logic [DATA_W-1:0]   q_wdata;
   logic                q_way;
   logic                rsp_valid_q;
   logic [DATA_W-1:0]   rsp_rdata_q;

   logic [NUM_WAYS-1:0]       hit_vec;
   logic [NUM_WAYS-1:0]       valid_vec;
   logic [NUM_WAYS-1:0]       dirty_vec;
   logic [NUM_WAYS*TAG_W-1:0] tag_vec;
   logic                      fifo_ptr;
   logic                      victim_way;
   logic                      victim_dirty;
   logic                      fill_en;
   logic                      acc_wr;
   logic [DATA_W-1:0]         rd_word;
   logic [BLOCK_W-1:0]        rd_block;
   logic [TAG_W-1:0]          old_tag;
   logic                      unused_low_addr;

   // byte lanes inside a word carry no meaning for a word access
   assign unused_low_addr = ^req_addr[BSEL_W-1:0];

   // empty way first (lowest index), then the set's FIFO pointer
   always_comb begin
      if (!valid_vec[0])      victim_way = 1'b0;
      else if (!valid_vec[1]) victim_way = 1'b1;
      else                    victim_way = fifo_ptr;
   end

   assign victim_dirty = valid_vec[victim_way] && dirty_vec[victim_way];
   assign fill_en      = (st == ST_FILL) && mem_rsp_valid;
   assign acc_wr       = (st == ST_ACC) && q_write;
   assign old_tag      = tag_vec[int'(q_way)*TAG_W +: TAG_W];

   cache2w_tag_store #(
      .SETS  (SETS),
      .TAG_W (TAG_W),
      .IDX_W (IDX_W)
   ) u_tags (
      .clk        (clk),
      .rst_n      (rst_n),
      .lk_idx     (q_idx),
      .lk_tag     (q_tag),
      .hit_vec    (hit_vec),
      .valid_vec  (valid_vec),
      .dirty_vec  (dirty_vec),
      .tag_vec    (tag_vec),
      .fifo_ptr   (fifo_ptr),
      .fill_en    (fill_en),
      .fill_way   (q_way),
      .fill_tag   (q_tag),
      .mark_dirty (acc_wr),
      .dirty_way  (q_way)
   );

   cache2w_data_store #(
      .SETS    (SETS),
      .IDX_W   (IDX_W),
      .DATA_W  (DATA_W),
      .WORDS   (WORDS),
      .WSEL_W  (WSEL_W),
      .BLOCK_W (BLOCK_W)
   ) u_data (
      .clk       (clk),
      .idx       (q_idx),
      .way       (q_way),
      .wsel      (q_wsel),
      .wr_en     (acc_wr),
      .be        (q_be),
      .wdata     (q_wdata),
      .fill_en   (fill_en),
      .fill_data (mem_rsp_data),
      .rd_word   (rd_word),
      .rd_block  (rd_block)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= ST_IDLE;
         q_write     <= 1'b0;
         q_tag       <= '0;
         q_idx       <= '0;
         q_wsel      <= '0;
         q_be        <= '0;
         q_wdata     <= '0;
         q_way       <= 1'b0;
         rsp_valid_q <= 1'b0;
         rsp_rdata_q <= '0;
      end else begin
         rsp_valid_q <= 1'b0;
         unique case (st)
            ST_IDLE: begin
               if (req_valid && req_ready) begin
                  q_write <= req_write;
                  q_tag   <= req_addr[ADDR_W-1 -: TAG_W];
                  q_idx   <= req_addr[OFF_W +: IDX_W];
                  q_wsel  <= req_addr[BSEL_W +: WSEL_W];
                  q_be    <= req_be;
                  q_wdata <= req_wdata;
                  st      <= ST_TAG;
               end
            end
            ST_TAG: begin
               if (|hit_vec) begin
                  q_way <= hit_vec[1];
                  st    <= ST_ACC;
               end else begin
                  q_way <= victim_way;
                  st    <= victim_dirty ? ST_EVICT : ST_FILL;
               end
            end
            ST_EVICT: begin
               if (!evict_full) st <= ST_FILL;
            end
            ST_FILL: begin
               if (mem_rsp_valid) st <= ST_ACC;
            end
            ST_ACC: begin
               if (!q_write) rsp_rdata_q <= rd_word;
               st <= ST_RSP;
            end
            ST_RSP: begin
               rsp_valid_q <= 1'b1;
               st          <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign req_ready     = (st == ST_IDLE) && !rsp_valid_q;
   assign rsp_valid     = rsp_valid_q;
   assign rsp_rdata     = rsp_rdata_q;
   assign mem_req_valid = (st == ST_FILL);
   assign mem_req_addr  = {q_tag, q_idx, OFF_W'(0)};
   assign evict_valid   = (st == ST_EVICT) && !evict_full;
   assign evict_addr    = {old_tag, q_idx, OFF_W'(0)};
   assign evict_data    = rd_block;

endmodule

// File: rtl/cache_2way_wb_chk.sv
module cache_2way_wb_chk
   import cache2w_pkg::*;
(
   input logic                clk,
   input logic                rst_n,
   input logic                req_ready,
   input logic                rsp_valid,
   input logic                evict_full,
   input logic                evict_valid,
   input logic                mem_req_valid,
   input logic [NUM_WAYS-1:0] hit_vec,
   input ctl_state_e          st
);

   AST_ONE_WAY_HITS: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec)); // R2

   AST_HIT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_TAG && (|hit_vec)) |-> ##3 rsp_valid); // R3

   AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid); // R3

   AST_BUSY_ON_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !req_ready); // R3

   AST_EVICT_BEFORE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      evict_valid |=> mem_req_valid); // R7

   AST_FULL_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_EVICT && evict_full) |=> (!mem_req_valid && !rsp_valid)); // R9

endmodule

bind cache_2way_wb cache_2way_wb_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_ready     (req_ready),
   .rsp_valid     (rsp_valid),
   .evict_full    (evict_full),
   .evict_valid   (evict_valid),
   .mem_req_valid (mem_req_valid),
   .hit_vec       (hit_vec),
   .st            (st)
);

// File: tb/tb_cache_2way_wb.sv
`timescale 1ns/1ps
module tb_cache_2way_wb;

   localparam int BW = 512;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic          req_write = 1'b0;
   logic [15:0]   req_addr = '0;
   logic [3:0]    req_be = '0;
   logic [31:0]   req_wdata = '0;
   logic          rsp_valid;
   logic [31:0]   rsp_rdata;
   logic          mem_req_valid;
   logic [15:0]   mem_req_addr;
   logic          mem_rsp_valid = 1'b0;
   logic [BW-1:0] mem_rsp_data = '0;
   logic          evict_full = 1'b0;
   logic          evict_valid;
   logic [15:0]   evict_addr;
   logic [BW-1:0] evict_data;

   int checks = 0;
   int failures = 0;
   int ev_cnt = 0;
   int mem_cnt = 0;
   logic [15:0]   ev_addr = '0;
   logic [BW-1:0] ev_data = '0;
   logic [15:0]   mem_addr_seen = '0;
   logic          mem_prev = 1'b0;

   always #4 clk = ~clk;

   cache_2way_wb dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .evict_full(evict_full), .evict_valid(evict_valid),
      .evict_addr(evict_addr), .evict_data(evict_data)
   );

   typedef struct packed {
      logic        wr;
      logic [15:0] addr;
      logic [3:0]  be;
      logic [31:0] wdata;
      logic        chk;
      logic [31:0] exp;
      logic        hit;
      logic        ev;
      logic [15:0] eaddr;
      logic [3:0]  ewsel;
      logic [31:0] eword;
   } vec_t;

   // sequence on set 0 (plus one access to set 1); address = tag<<8 | set<<6 | word<<2
   localparam vec_t VEC [12] = '{
      '{1'b0, 16'h0100, 4'hF, 32'h0,        1'b1, 32'h0100E000, 1'b0, 1'b0, 16'h0,    4'd0, 32'h0},
      '{1'b0, 16'h010C, 4'hF, 32'h0,        1'b1, 32'h0100E003, 1'b1, 1'b0, 16'h0,    4'd0, 32'h0},
      '{1'b1, 16'h010C, 4'h3, 32'hDEADBEEF, 1'b0, 32'h0,        1'b1, 1'b0, 16'h0,    4'd0, 32'h0},
      '{1'b0, 16'h010C, 4'hF, 32'h0,        1'b1, 32'h0100BEEF, 1'b1, 1'b0, 16'h0,    4'd0, 32'h0},
      '{1'b1, 16'h0204, 4'hF, 32'h12345678, 1'b0, 32'h0,        1'b0, 1'b0, 16'h0,    4'd0, 32'h0},
      '{1'b0, 16'h0204, 4'hF, 32'h0,        1'b1, 32'h12345678, 1'b1, 1'b0, 16'h0,    4'd0, 32'h0},
      '{1'b0, 16'h0208, 4'hF, 32'h0,        1'b1, 32'h0200E002, 1'b1, 1'b0, 16'h0,    4'd0, 32'h0},
      '{1'b0, 16'h0300, 4'hF, 32'h0,        1'b1, 32'h0300E000, 1'b0, 1'b1, 16'h0100, 4'd3, 32'h0100BEEF},
      '{1'b0, 16'h010C, 4'hF, 32'h0,        1'b1, 32'h0100E003, 1'b0, 1'b1, 16'h0200, 4'd1, 32'h12345678},
      '{1'b0, 16'h0040, 4'hF, 32'h0,        1'b1, 32'h0040E000, 1'b0, 1'b0, 16'h0,    4'd0, 32'h0},
      '{1'b0, 16'h0303, 4'hF, 32'h0,        1'b1, 32'h0300E000, 1'b1, 1'b0, 16'h0,    4'd0, 32'h0},
      '{1'b0, 16'h0400, 4'hF, 32'h0,        1'b1, 32'h0400E000, 1'b0, 1'b0, 16'h0,    4'd0, 32'h0}
   };

   function automatic logic [BW-1:0] block_of(input logic [15:0] a);
      logic [BW-1:0] b;
      for (int w = 0; w < 16; w++) b[w*32 +: 32] = {a, 8'hE0, 8'(w)};
      return b;
   endfunction

   task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   task automatic start_req(input logic wr, input logic [15:0] a, input logic [3:0] be, input logic [31:0] wd);
      req_write = wr; req_addr = a; req_be = be; req_wdata = wd; req_valid = 1'b1;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic finish_req(output int lat, output logic [31:0] rd);
      lat = 0;
      while (!rsp_valid) begin
         @(negedge clk);
         lat++;
      end
      rd = rsp_rdata;
      req_valid = 1'b0;
      @(negedge clk);
   endtask

   // sampled shortly before each rising edge
   initial begin
      forever begin
         @(negedge clk);
         #2;
         if (evict_valid) begin
            ev_cnt++;
            ev_addr = evict_addr;
            ev_data = evict_data;
         end
         if (mem_req_valid && !mem_prev) begin
            mem_cnt++;
            mem_addr_seen = mem_req_addr;
         end
         mem_prev = mem_req_valid;
      end
   end

   // next-level memory: fixed contents, fixed delay
   initial begin
      forever begin
         @(negedge clk);
         if (mem_req_valid) begin
            repeat (4) @(negedge clk);
            mem_rsp_data  = block_of(mem_req_addr);
            mem_rsp_valid = 1'b1;
            @(negedge clk);
            mem_rsp_valid = 1'b0;
         end
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      failures++;
      $display("FAIL R3 watchdog actual=timeout expected=completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int lat;
      logic [31:0] rd;
      int ev0, m0;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready == 1'b1, "R11 req_ready after reset", 64'(req_ready), 64'd1);
      check(rsp_valid == 1'b0, "R11 rsp_valid after reset", 64'(rsp_valid), 64'd0);
      check(mem_req_valid == 1'b0, "R11 mem_req_valid after reset", 64'(mem_req_valid), 64'd0);
      check(evict_valid == 1'b0, "R11 evict_valid after reset", 64'(evict_valid), 64'd0);

      for (int i = 0; i < 12; i++) begin
         ev0 = ev_cnt;
         m0  = mem_cnt;
         start_req(VEC[i].wr, VEC[i].addr, VEC[i].be, VEC[i].wdata);
         finish_req(lat, rd);
         if (VEC[i].chk)
            check(rd == VEC[i].exp, $sformatf("R1 R2 R4 R5 read data vec %0d", i), 64'(rd), 64'(VEC[i].exp));
         if (VEC[i].hit) begin
            check(lat == 3, $sformatf("R3 hit latency vec %0d", i), 64'(lat), 64'd3);
            check(mem_cnt == m0, $sformatf("R2 no refill on hit vec %0d", i), 64'(mem_cnt - m0), 64'd0);
         end else begin
            check(lat > 3, $sformatf("R12 miss slower than hit vec %0d", i), 64'(lat), 64'd4);
            check(mem_cnt == m0 + 1, $sformatf("R12 one refill vec %0d", i), 64'(mem_cnt - m0), 64'd1);
            check(mem_addr_seen == {VEC[i].addr[15:6], 6'd0}, $sformatf("R12 refill address vec %0d", i),
                  64'(mem_addr_seen), 64'({VEC[i].addr[15:6], 6'd0}));
         end
         check(ev_cnt == ev0 + int'(VEC[i].ev), $sformatf("R7 R8 eviction count vec %0d", i),
               64'(ev_cnt - ev0), 64'(VEC[i].ev));
         if (VEC[i].ev) begin
            check(ev_addr == VEC[i].eaddr, $sformatf("R6 R7 evicted block address vec %0d", i),
                  64'(ev_addr), 64'(VEC[i].eaddr));
            check(ev_data[int'(VEC[i].ewsel)*32 +: 32] == VEC[i].eword, $sformatf("R7 evicted word vec %0d", i),
                  64'(ev_data[int'(VEC[i].ewsel)*32 +: 32]), 64'(VEC[i].eword));
         end
      end

      // set 2: two dirty lines, pointer back at way 0
      start_req(1'b1, 16'h0180, 4'hF, 32'hCAFEF00D);
      finish_req(lat, rd);
      start_req(1'b1, 16'h0280, 4'hF, 32'h0BADC0DE);
      finish_req(lat, rd);

      // R10: buffer full does not slow a hit
      evict_full = 1'b1;
      start_req(1'b0, 16'h0280, 4'hF, 32'h0);
      finish_req(lat, rd);
      check(lat == 3, "R10 hit latency with buffer full", 64'(lat), 64'd3);
      check(rd == 32'h0BADC0DE, "R10 hit data with buffer full", 64'(rd), 64'h0BADC0DE);

      // R9: dirty victim with buffer full stalls the miss
      ev0 = ev_cnt;
      m0  = mem_cnt;
      start_req(1'b0, 16'h0380, 4'hF, 32'h0);
      begin
         bit quiet = 1'b1;
         for (int k = 0; k < 20; k++) begin
            if (rsp_valid || mem_req_valid) quiet = 1'b0;
            @(negedge clk);
         end
         check(quiet, "R9 no refill or response while full", 64'(quiet), 64'd1);
         check(ev_cnt == ev0, "R9 no eviction while full", 64'(ev_cnt - ev0), 64'd0);
         check(mem_cnt == m0, "R9 no refill request while full", 64'(mem_cnt - m0), 64'd0);
      end
      evict_full = 1'b0;
      finish_req(lat, rd);
      check(ev_cnt == ev0 + 1, "R9 eviction after release", 64'(ev_cnt - ev0), 64'd1);
      check(ev_addr == 16'h0180, "R6 R7 victim address after release", 64'(ev_addr), 64'h0180);
      check(ev_data[31:0] == 32'hCAFEF00D, "R7 victim data after release", 64'(ev_data[31:0]), 64'hCAFEF00D);
      check(mem_addr_seen == 16'h0380, "R12 refill address after release", 64'(mem_addr_seen), 64'h0380);
      check(rd == 32'h0380E000, "R9 response data after release", 64'(rd), 64'h0380E000);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule